// File: doc/BRIEF.md
# Page-Table-Walking Address Translator

This unit sits between a processor's memory port and a cache port. It turns 32-bit virtual word addresses into physical ones using a single-level page table held in ordinary memory. A translated request takes two cache accesses in sequence. The first reads the table entry for the page. The second performs the data read or write at the physical address built from that entry. Two configuration inputs define the table: a 20-bit origin, which gives the table base in 4 KiB units, and a 20-bit length, which gives the number of entries.

An untranslated request skips the table. Its address goes straight to the cache port and one access is made. Two kinds of check can stop a translated request before its data access: a page index beyond the table length, and a table entry that is invalid or lacks the needed permission. In either case the unit reports a one-cycle exception with a cause code and the faulting address, and returns to idle.

The processor asserts its request together with a translate flag, read and write strobes, an address and write data. From the cycle after the request until the sequence ends, the unit holds busy high. While busy is high the processor must keep those inputs unchanged.

Top module: `pt_walk_mmu`

## Requirements
- R1: After reset, `cpu_busy`, `mem_rd`, `mem_wr` and `exc_valid` are all 0.
- R2: A translated request whose page index (virtual address bits 31:12) is inside the table first reads the cache at word address `{pt_origin, 10'b0} + page_index`.
- R3: A translated request with page index >= `pt_length` makes no cache access and reports cause 2'b01.
- R4: When translation succeeds, the data access uses word address `{pte[31:12], va[11:2]}`, and on a read the word returned by the cache appears on `cpu_rdata` once busy falls.
- R5: A translated or untranslated write drives `mem_wr` with `cpu_wdata` at the target address, so memory holds that word afterwards.
- R6: A table entry whose valid flag (bit 2) is 0 gives cause 2'b10. The only cache access made is the entry read.
- R7: A request counts as a read when `cpu_rd`=1 or `cpu_wr`=0, and as a write otherwise. A read needs entry bit 0 (read right) and a write needs entry bit 1 (write right). A missing right gives cause 2'b11, with the entry read as the only access.
- R8: An untranslated request makes exactly one cache access, at `cpu_addr` unchanged.
- R9: `cpu_busy` is 1 from the cycle after the accepted request until the sequence ends. A cache strobe and `mem_addr` stay unchanged while `mem_busy` is 1.
- R10: An exception raises `exc_valid` for exactly one cycle, with `cpu_busy` already 0. `exc_cause` and `exc_vaddr` keep the cause and faulting word address until the next exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request from the processor |
| cpu_xlat | input | 1 | 1 = translate through the page table |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 30 | Word address (byte address bits 31:2) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when busy falls after a read |
| cpu_busy | output | 1 | Sequence in progress |
| pt_origin | input | 20 | Page-table base in 4 KiB units |
| pt_length | input | 20 | Number of table entries |
| mem_rd | output | 1 | Cache read strobe |
| mem_wr | output | 1 | Cache write strobe |
| mem_addr | output | 30 | Cache word address |
| mem_wdata | output | 32 | Cache write data |
| mem_rdata | input | 32 | Cache read data, valid when busy is low |
| mem_busy | input | 1 | Cache still working on the current strobe |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 2 | 01 length, 10 invalid, 11 rights |
| exc_vaddr | output | 30 | Faulting virtual word address |

## Verification
The hardest case to reach from the ports is a cache that stays busy for several cycles on the entry read and then answers with no busy cycles on the data access, or the reverse. That mix shows whether the captured entry survives the wait and whether the strobes are held. The bench memory model draws a fresh latency of 0 to 3 cycles for each access from a seeded generator, so every request mixes latencies. Directed requests add the boundary indices `pt_length-1`, `pt_length` and the largest index, as well as entries that are invalid, read-only or write-only.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PTEA, ST_SETA, ST_RDPTE, ST_CPA, ST_READ, ST_WRITE
  } ptw_state_e;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'b00,
    EXC_LEN    = 2'b01,
    EXC_INV    = 2'b10,
    EXC_RIGHTS = 2'b11
  } ptw_cause_e;

  localparam int FLAG_VALID = 2;
  localparam int FLAG_WRITE = 1;
  localparam int FLAG_READ  = 0;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int A_W   = 32,
  parameter int OFS_W = 12
) (
  input  logic [A_W-1:2]     vaddr,
  input  logic [A_W-OFS_W-1:0] origin,
  input  logic [A_W-OFS_W-1:0] length,
  input  logic [A_W-OFS_W-1:0] ppx,
  output logic [A_W-1:2]     pte_waddr,
  output logic               len_fault,
  output logic [A_W-1:2]     phys_waddr
);
  localparam int PIX_W = A_W - OFS_W;
  localparam int WOFS_W = OFS_W - 2;

  logic [PIX_W-1:0] pix;
  assign pix = vaddr[A_W-1:OFS_W];

  // entry address: table base plus one word per page index
  assign pte_waddr  = {origin, {WOFS_W{1'b0}}} + {{(A_W-2-PIX_W){1'b0}}, pix};
  assign len_fault  = (pix >= length);
  assign phys_waddr = {ppx, vaddr[OFS_W-1:2]};
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [2:0]  flags,
  input  logic        is_read,
  output logic        fault,
  output ptw_cause_e  cause
);
  always_comb begin
    fault = 1'b0;
    cause = EXC_NONE;
    if (!flags[FLAG_VALID]) begin
      fault = 1'b1;
      cause = EXC_INV;
    end else if (is_read ? !flags[FLAG_READ] : !flags[FLAG_WRITE]) begin
      fault = 1'b1;
      cause = EXC_RIGHTS;
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       xlat,
  input  logic       is_read,
  input  logic       mem_busy,
  input  logic       len_fault,
  input  logic       pte_fault,
  output ptw_state_e state,
  output logic       exc_fire,
  output logic       exc_len,
  output logic       mem_rd_q,
  output logic       mem_wr_q,
  output logic       busy_q
);
  ptw_state_e nxt;

  always_comb begin
    nxt      = state;
    exc_fire = 1'b0;
    exc_len  = 1'b0;
    unique case (state)
      ST_IDLE:  if (req) nxt = xlat ? ST_PTEA : ST_SETA;
      ST_PTEA: begin
        if (len_fault) begin
          nxt      = ST_IDLE;
          exc_fire = 1'b1;
          exc_len  = 1'b1;
        end else begin
          nxt = ST_RDPTE;
        end
      end
      ST_SETA:  nxt = is_read ? ST_READ : ST_WRITE;
      ST_RDPTE: if (!mem_busy) nxt = ST_CPA;
      ST_CPA: begin
        if (pte_fault) begin
          nxt      = ST_IDLE;
          exc_fire = 1'b1;
        end else begin
          nxt = is_read ? ST_READ : ST_WRITE;
        end
      end
      ST_READ, ST_WRITE: if (!mem_busy) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_rd_q <= 1'b0;
      mem_wr_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      state    <= nxt;
      mem_rd_q <= (nxt == ST_RDPTE) || (nxt == ST_READ);
      mem_wr_q <= (nxt == ST_WRITE);
      busy_q   <= (nxt != ST_IDLE);
    end
  end

  // R9
  strobe_hold_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_q && mem_busy) |=> mem_rd_q);
  // R9
  strobe_hold_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_q && mem_busy) |=> mem_wr_q);
endmodule

// File: rtl/pt_walk_mmu.sv
module pt_walk_mmu
  import ptw_pkg::*;
#(
  parameter int A_W   = 32,
  parameter int OFS_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req,
  input  logic                 cpu_xlat,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [A_W-1:2]       cpu_addr,
  input  logic [A_W-1:0]       cpu_wdata,
  output logic [A_W-1:0]       cpu_rdata,
  output logic                 cpu_busy,
  input  logic [A_W-OFS_W-1:0] pt_origin,
  input  logic [A_W-OFS_W-1:0] pt_length,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [A_W-1:2]       mem_addr,
  output logic [A_W-1:0]       mem_wdata,
  input  logic [A_W-1:0]       mem_rdata,
  input  logic                 mem_busy,
  output logic                 exc_valid,
  output logic [1:0]           exc_cause,
  output logic [A_W-1:2]       exc_vaddr
);
  localparam int PIX_W = A_W - OFS_W;

  ptw_state_e     state;
  logic           is_read, exc_fire, exc_len, len_fault, pte_fault;
  ptw_cause_e     pte_cause;
  logic [A_W-1:2] ar_q, pte_waddr, phys_waddr;
  logic [A_W-1:0] dr_q;

  assign is_read = cpu_rd | ~cpu_wr;

  ptw_addr_gen #(.A_W(A_W), .OFS_W(OFS_W)) u_addr (
    .vaddr(cpu_addr), .origin(pt_origin), .length(pt_length),
    .ppx(dr_q[A_W-1:OFS_W]), .pte_waddr(pte_waddr),
    .len_fault(len_fault), .phys_waddr(phys_waddr));

  ptw_pte_check u_chk (
    .flags(dr_q[2:0]), .is_read(is_read), .fault(pte_fault), .cause(pte_cause));

  ptw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(cpu_req), .xlat(cpu_xlat), .is_read(is_read),
    .mem_busy(mem_busy), .len_fault(len_fault), .pte_fault(pte_fault),
    .state(state), .exc_fire(exc_fire), .exc_len(exc_len),
    .mem_rd_q(mem_rd), .mem_wr_q(mem_wr), .busy_q(cpu_busy));

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q      <= '0;
      dr_q      <= '0;
      exc_valid <= 1'b0;
      exc_cause <= EXC_NONE;
      exc_vaddr <= '0;
    end else begin
      case (state)
        ST_PTEA: ar_q <= pte_waddr;
        ST_SETA: ar_q <= cpu_addr;
        ST_CPA:  ar_q <= phys_waddr;
        default: ;
      endcase
      if (state == ST_RDPTE || state == ST_READ) dr_q <= mem_rdata;
      exc_valid <= exc_fire;
      if (exc_fire) begin
        exc_cause <= exc_len ? EXC_LEN : pte_cause;
        exc_vaddr <= cpu_addr;
      end
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = cpu_wdata;
  assign cpu_rdata = dr_q;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_busy) |=> $stable(mem_addr));
  // R10
  exc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);
  // R10
  exc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !cpu_busy);
  // R3
  exc_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $past(!mem_rd && !mem_wr));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_busy && !mem_rd && !mem_wr && !exc_valid));

  logic unused_ok;
  assign unused_ok = ^{PIX_W[0]};
endmodule

// File: tb/tb_pt_walk_mmu.sv
module tb_pt_walk_mmu;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] ORIGIN = 20'h00001;
  localparam logic [19:0] LENGTH = 20'd48;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_xlat = 0, cpu_rd = 0, cpu_wr = 0;
  logic [31:2] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_busy, mem_rd, mem_wr, mem_busy, exc_valid;
  logic [31:2] mem_addr, exc_vaddr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [1:0] exc_cause;
  logic [19:0] pt_origin = ORIGIN, pt_length = LENGTH;

  int total = 0, bad = 0;
  logic [31:0] mem [0:4095];
  int wait_cnt = 0;
  bit mon_on = 0, prev_strobe = 0;
  int acc_cnt = 0, exc_cnt = 0;
  logic [31:2] first_addr, last_addr;
  bit last_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walk_mmu dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_xlat(cpu_xlat),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
    .pt_origin(pt_origin), .pt_length(pt_length), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_vaddr(exc_vaddr));

  // cache model with a random 0..3 cycle latency per access
  assign mem_busy  = (mem_rd || mem_wr) && (wait_cnt != 0);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (!(mem_rd || mem_wr)) wait_cnt <= int'($urandom % 4);
    else if (wait_cnt != 0) wait_cnt <= wait_cnt - 1;
    if (mem_wr && wait_cnt == 0) mem[mem_addr[13:2]] <= mem_wdata;
  end

  // monitor samples the previous cycle's values at each rising edge
  always @(posedge clk) begin
    if (mon_on) begin
      if ((mem_rd || mem_wr) && !prev_strobe) begin
        acc_cnt++;
        if (acc_cnt == 1) first_addr = mem_addr;
        last_addr = mem_addr;
        last_wr = mem_wr;
      end
      if (exc_valid) exc_cnt++;
    end
    prev_strobe = mem_rd || mem_wr;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [1:0]  hold_cause = 2'b00;
  logic [31:2] hold_vaddr = '0;

  task automatic run_req(input bit x, input bit rd, input bit wr,
                         input logic [31:0] va, input logic [31:0] wd);
    logic [19:0] pix;
    logic [31:2] pte_wa, phys_wa;
    logic [31:0] pte, exp_rd;
    logic [1:0] cause;
    bit is_rd;
    int n;
    is_rd = rd || !wr;
    pix = va[31:12];
    pte_wa = {ORIGIN, 10'b0} + {10'b0, pix};
    pte = mem[pte_wa[13:2]];
    cause = 2'b00;
    phys_wa = va[31:2];
    if (x) begin
      if (pix >= LENGTH) cause = 2'b01;
      else if (!pte[2]) cause = 2'b10;
      else if (is_rd ? !pte[0] : !pte[1]) cause = 2'b11;
      phys_wa = {pte[31:12], va[11:2]};
    end
    exp_rd = mem[phys_wa[13:2]];

    @(negedge clk);
    acc_cnt = 0; exc_cnt = 0; mon_on = 1;
    cpu_req = 1; cpu_xlat = x; cpu_rd = rd; cpu_wr = wr;
    cpu_addr = va[31:2]; cpu_wdata = wd;
    @(posedge clk); @(negedge clk);
    chk(cpu_busy == 1'b1, "R9 busy after request", {31'b0, cpu_busy}, 32'd1);
    n = 0;
    while (cpu_busy && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk(1'b0, "R9 watchdog on request", n, 200);
    cpu_req = 0;
    @(posedge clk); @(negedge clk);
    mon_on = 0;

    if (cause != 2'b00) begin
      hold_cause = cause; hold_vaddr = va[31:2];
      chk(exc_cnt == 1, "R10 one exception pulse", exc_cnt, 1);
    end else begin
      chk(exc_cnt == 0, "R10 no exception", exc_cnt, 0);
    end
    chk(exc_cause == hold_cause, "R10 cause held", {30'b0, exc_cause}, {30'b0, hold_cause});
    chk(exc_vaddr == hold_vaddr, "R10 vaddr held", {exc_vaddr, 2'b0}, {hold_vaddr, 2'b0});

    if (!x) begin
      chk(acc_cnt == 1, "R8 single access", acc_cnt, 1);
      chk(last_addr == va[31:2], "R8 address passed through", {last_addr, 2'b0}, {va[31:2], 2'b0});
    end else if (cause == 2'b01) begin
      chk(acc_cnt == 0, "R3 no access on length fault", acc_cnt, 0);
    end else begin
      chk(first_addr == pte_wa, "R2 entry address", {first_addr, 2'b0}, {pte_wa, 2'b0});
      if (cause == 2'b10) chk(acc_cnt == 1, "R6 only entry read", acc_cnt, 1);
      else if (cause == 2'b11) chk(acc_cnt == 1, "R7 only entry read", acc_cnt, 1);
      else begin
        chk(acc_cnt == 2, "R4 two accesses", acc_cnt, 2);
        chk(last_addr == phys_wa, "R4 physical address", {last_addr, 2'b0}, {phys_wa, 2'b0});
      end
    end
    if (cause == 2'b00) begin
      if (is_rd) chk(cpu_rdata == exp_rd, "R4 read data", cpu_rdata, exp_rd);
      else begin
        chk(last_wr == 1'b1, "R5 write strobe used", {31'b0, last_wr}, 32'd1);
        chk(mem[phys_wa[13:2]] == wd, "R5 written word", mem[phys_wa[13:2]], wd);
      end
    end
  endtask

  function automatic logic [31:0] mk_pte(input int p, input logic [2:0] fl);
    return {20'(2 + (p % 2)), 9'b0, fl};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R9 global watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    for (int p = 0; p < 64; p++) mem[1024 + p] = mk_pte(p, 3'($urandom));
    mem[1024 + 10] = mk_pte(10, 3'b111);
    mem[1024 + 11] = mk_pte(11, 3'b011);
    mem[1024 + 12] = mk_pte(12, 3'b101);
    mem[1024 + 13] = mk_pte(13, 3'b110);
    mem[1024 + 47] = mk_pte(47, 3'b111);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cpu_busy == 0, "R1 busy low", {31'b0, cpu_busy}, 0);
    chk(mem_rd == 0 && mem_wr == 0, "R1 strobes low", {30'b0, mem_rd, mem_wr}, 0);
    chk(exc_valid == 0, "R1 no exception", {31'b0, exc_valid}, 0);
    rst = 0;

    // directed corner cases
    run_req(1, 1, 0, {20'd10, 12'h344}, 0);          // R4 translated read
    run_req(1, 0, 1, {20'd10, 12'h018}, 32'hCAFE0001); // R5 translated write
    run_req(1, 1, 0, {20'd47, 12'hFFC}, 0);          // R2 last entry in table
    run_req(1, 1, 0, {20'd48, 12'h000}, 0);          // R3 first index out of range
    run_req(1, 0, 1, {20'hFFFFF, 12'h123}, 32'h1);   // R3 largest index
    run_req(1, 1, 0, {20'd11, 12'h100}, 0);          // R6 invalid entry
    run_req(1, 0, 1, {20'd12, 12'h100}, 32'h5);      // R7 write without right
    run_req(1, 1, 0, {20'd13, 12'h100}, 0);          // R7 read without right
    run_req(1, 0, 1, {20'd13, 12'h204}, 32'h77);     // R5 write-only page
    run_req(1, 0, 0, {20'd13, 12'h208}, 0);          // R7 neither strobe = read
    run_req(0, 1, 0, 32'h0000_2ABC, 0);              // R8 untranslated read
    run_req(0, 0, 1, 32'h0000_3F00, 32'hBEEF);       // R8 untranslated write

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      bit x, rd, wr;
      logic [31:0] va;
      x  = ($urandom % 5) != 0;
      rd = $urandom % 2;
      wr = !rd || (($urandom % 4) == 0);
      if (x) va = {20'($urandom % 56), 12'($urandom)};
      else   va = {19'b0, 1'b1, 12'($urandom)} | (32'($urandom % 2) << 12);
      if (x && ($urandom % 20) == 0) va[31:12] = 20'($urandom);
      run_req(x, rd, wr, va, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule